// File: doc/BRIEF.md
# Synchronous Transmit End-of-Frame Sequencer

This block controls the transmit side of a byte-oriented synchronous serial channel. A processor writes bytes into a single holding buffer. At each byte boundary the block moves the next byte into a shift register. The shift register drives the line one bit per bit-clock enable, least significant bit first. When the buffer runs dry with the end-of-message latch armed, the block closes the frame. It sends the two check bytes of a running CRC, then a fill byte. The fill byte is a fixed flag, or a programmable sync byte in sync mode. While no frame is active, the line carries fill bytes.

A mode input decides what happens to a byte written while the check bytes are going out. In legacy mode new data wins over the CRC: any check byte not yet loaded is dropped, a fill byte is sent in its place, and the new byte opens a fresh frame. In enhanced mode the CRC wins: the byte waits in the buffer until both check bytes and the fill byte have been loaded. The buffer-empty flag and the sticky transmit-interrupt flag follow separate rules around this handoff, so software can tell where the frame stands.

Top module: `syncTxEofSeq`

## Requirements
- R1: After reset, txBufEmpty is 1, txIntPend is 0, eomDone is 1 and the line carries fill bytes.
- R2: Each byte is shifted out least significant bit first, one bit per cycle with bitEn high, and byte boundaries fall every 8 bitEn pulses from reset. With no frame active, every byte sent is a fill byte: 8'h7E when syncMode is 0, syncByte when syncMode is 1.
- R3: Pulsing wrEn stores wrByte in the buffer and drives txBufEmpty to 0. At the next byte boundary the stored byte goes into the shift register, txBufEmpty returns to 1 and txIntPend is set.
- R4: cmdArmEom drives eomDone to 0. If a frame is active, the latch is armed and the buffer is empty at a byte boundary, the high check byte is loaded and eomDone returns to 1 in that same cycle. The low check byte follows, then one fill byte, and the frame closes.
- R5: The check value is a CRC-16 with polynomial 16'h1021 and preset 16'hFFFF, taken over the frame's data bytes with each byte's MSB entering first. It is transmitted inverted, high byte first. It is preset again for every frame.
- R6: If the buffer runs dry during a frame while eomDone is 1, a fill byte is sent in place of any check byte, the frame closes and eomDone stays 1.
- R7: With enhMode 1, a byte written after the high check byte is loaded stays in the buffer. It is sent after the low check byte and one fill byte, as the first byte of a new frame.
- R8: With enhMode 1, when the closing fill byte is loaded with a byte waiting in the buffer, txIntPend is set while txBufEmpty stays 0.
- R9: With enhMode 0, if the buffer is full at the boundary that would load the low check byte, a fill byte is loaded instead. The waiting byte follows as the first byte of a new frame, and txIntPend is set when that fill byte loads.
- R10: txIntPend also sets when the closing fill byte loads after a complete CRC. It stays at 1 until cmdRstTxIp is pulsed. When a set event and cmdRstTxIp fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit-clock enable; one line bit per high cycle |
| enhMode | input | 1 | 1: CRC has priority over new data; 0: data has priority |
| syncMode | input | 1 | 1: fill byte is syncByte; 0: fill byte is the flag 8'h7E |
| syncByte | input | 8 | Programmable sync fill byte |
| wrEn | input | 1 | Processor write strobe for the transmit buffer |
| wrByte | input | 8 | Processor write data |
| cmdArmEom | input | 1 | Command strobe: arm the end-of-message latch |
| cmdRstTxIp | input | 1 | Command strobe: clear the transmit interrupt flag |
| txOut | output | 1 | Serial line output |
| txBufEmpty | output | 1 | Transmit buffer empty status |
| txIntPend | output | 1 | Sticky transmit interrupt pending |
| eomDone | output | 1 | End-of-message latch; 0 when armed |

## Verification
Two functions can fall in the same cycle. A byte leaving the buffer sets txIntPend, and software may issue the command that clears it in that same cycle. The bench tracks its own bit position and pulses cmdRstTxIp in exactly the cycle whose edge performs the load. It then expects txIntPend still at 1 and txBufEmpty at 1. The serial stream is judged by a scoreboard against frames, check bytes and dropped check bytes predicted in the bench.

// File: rtl/syncTxEofPkg.sv
package syncTxEofPkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_CRC1,
    ST_CRC2
  } txStateT;

  typedef struct packed {
    logic ldData;
    logic crcPreset;
    logic ldCrcHi;
    logic ldCrcLo;
    logic ldFill;
  } txStrobeT;

  // One byte through the CRC, most significant bit first.
  function automatic logic [CRC_W-1:0] crcStep(
    input logic [CRC_W-1:0]  crcIn,
    input logic [BYTE_W-1:0] dataIn,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] acc;
    acc = crcIn ^ {dataIn, {(CRC_W-BYTE_W){1'b0}}};
    for (int i = 0; i < BYTE_W; i++) begin
      if (acc[CRC_W-1]) acc = (acc << 1) ^ poly;
      else              acc = acc << 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/syncTxEofCtrl.sv
module syncTxEofCtrl
  import syncTxEofPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     byteEnd,
  input  logic     enhMode,
  input  logic     wrEn,
  input  logic     cmdArmEom,
  input  logic     cmdRstTxIp,
  output txStrobeT stb,
  output logic     txBufEmpty,
  output logic     txIntPend,
  output logic     eomDone
);

  txStateT stCur, stNext;
  logic    bufFull;
  logic    raiseIp;
  logic    setEom;

  // Load decision, taken only at a byte boundary.
  always_comb begin
    stb     = '0;
    stNext  = stCur;
    raiseIp = 1'b0;
    setEom  = 1'b0;
    if (byteEnd) begin
      case (stCur)
        ST_IDLE: begin
          if (bufFull) begin
            stb.ldData    = 1'b1;
            stb.crcPreset = 1'b1;
            stNext        = ST_DATA;
          end else begin
            stb.ldFill = 1'b1;
          end
        end
        ST_DATA: begin
          if (bufFull) begin
            stb.ldData = 1'b1;
          end else if (!eomDone) begin
            stb.ldCrcHi = 1'b1;
            setEom      = 1'b1;
            stNext      = ST_CRC1;
          end else begin
            stb.ldFill = 1'b1;
            stNext     = ST_IDLE;
          end
        end
        ST_CRC1: begin
          if (!enhMode && bufFull) begin
            stb.ldFill = 1'b1;
            raiseIp    = 1'b1;
            stNext     = ST_IDLE;
          end else begin
            stb.ldCrcLo = 1'b1;
            stNext      = ST_CRC2;
          end
        end
        default: begin
          stb.ldFill = 1'b1;
          raiseIp    = 1'b1;
          stNext     = ST_IDLE;
        end
      endcase
    end
    if (stb.ldData) raiseIp = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stCur     <= ST_IDLE;
      bufFull   <= 1'b0;
      txIntPend <= 1'b0;
      eomDone   <= 1'b1;
    end else begin
      stCur <= stNext;

      if (wrEn)            bufFull <= 1'b1;
      else if (stb.ldData) bufFull <= 1'b0;

      if (raiseIp)         txIntPend <= 1'b1;
      else if (cmdRstTxIp) txIntPend <= 1'b0;

      if (setEom)          eomDone <= 1'b1;
      else if (cmdArmEom)  eomDone <= 1'b0;
    end
  end

  assign txBufEmpty = !bufFull;

  AST_IP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (txIntPend && !cmdRstTxIp) |=> txIntPend); // R10

  AST_CRC_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (stCur == ST_CRC1 && byteEnd && enhMode) |=> (stCur == ST_CRC2)); // R7

  AST_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ((stCur == ST_CRC1 || stCur == ST_CRC2) && enhMode && bufFull) |=> bufFull); // R8

  AST_EOM_FROM_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eomDone) |-> ($past(stCur) == ST_DATA && stCur == ST_CRC1)); // R4

  AST_LEGACY_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (stCur == ST_CRC1 && byteEnd && !enhMode && bufFull) |=> (stCur == ST_IDLE && txIntPend)); // R9

endmodule

// File: rtl/syncTxEofDatapath.sv
module syncTxEofDatapath
  import syncTxEofPkg::*;
#(
  parameter logic [BYTE_W-1:0] FLAG_PATTERN = 8'h7E,
  parameter logic [CRC_W-1:0]  CRC_POLY     = 16'h1021,
  parameter logic [CRC_W-1:0]  CRC_INIT     = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              syncMode,
  input  logic [BYTE_W-1:0] syncByte,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrByte,
  input  txStrobeT          stb,
  output logic              byteEnd,
  output logic              txOut
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] bufReg;
  logic [CRC_W-1:0]  crcReg;
  logic [CRC_W-1:0]  crcSeed;
  logic [BYTE_W-1:0] fillByte;
  logic [BYTE_W-1:0] loadByte;

  assign byteEnd  = bitEn && (bitCnt == LAST_BIT);
  assign fillByte = syncMode ? syncByte : FLAG_PATTERN;
  assign crcSeed  = stb.crcPreset ? CRC_INIT : crcReg;

  always_comb begin
    loadByte = fillByte;
    if (stb.ldData)       loadByte = bufReg;
    else if (stb.ldCrcHi) loadByte = ~crcReg[CRC_W-1:BYTE_W];
    else if (stb.ldCrcLo) loadByte = ~crcReg[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= FLAG_PATTERN;
      bufReg   <= '0;
      crcReg   <= CRC_INIT;
    end else begin
      if (bitEn) bitCnt <= bitCnt + 1'b1;

      if (byteEnd)    shiftReg <= loadByte;
      else if (bitEn) shiftReg <= shiftReg >> 1;

      if (wrEn) bufReg <= wrByte;

      if (stb.ldData) crcReg <= crcStep(crcSeed, bufReg, CRC_POLY);
    end
  end

  assign txOut = shiftReg[0];

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldData, stb.ldCrcHi, stb.ldCrcLo, stb.ldFill})); // R4

  AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldData || stb.ldCrcHi || stb.ldCrcLo || stb.ldFill) |-> byteEnd); // R2

  AST_BYTE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    byteEnd |=> (bitCnt == '0)); // R2

  AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldData |=> $stable(crcReg)); // R5

endmodule

// File: rtl/syncTxEofSeq.sv
module syncTxEofSeq
  import syncTxEofPkg::*;
#(
  parameter logic [BYTE_W-1:0] FLAG_PATTERN = 8'h7E,
  parameter logic [CRC_W-1:0]  CRC_POLY     = 16'h1021,
  parameter logic [CRC_W-1:0]  CRC_INIT     = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              enhMode,
  input  logic              syncMode,
  input  logic [BYTE_W-1:0] syncByte,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              cmdArmEom,
  input  logic              cmdRstTxIp,
  output logic              txOut,
  output logic              txBufEmpty,
  output logic              txIntPend,
  output logic              eomDone
);

  txStrobeT stb;
  logic     byteEnd;

  syncTxEofCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .byteEnd    (byteEnd),
    .enhMode    (enhMode),
    .wrEn       (wrEn),
    .cmdArmEom  (cmdArmEom),
    .cmdRstTxIp (cmdRstTxIp),
    .stb        (stb),
    .txBufEmpty (txBufEmpty),
    .txIntPend  (txIntPend),
    .eomDone    (eomDone)
  );

  syncTxEofDatapath #(
    .FLAG_PATTERN (FLAG_PATTERN),
    .CRC_POLY     (CRC_POLY),
    .CRC_INIT     (CRC_INIT)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .syncMode (syncMode),
    .syncByte (syncByte),
    .wrEn     (wrEn),
    .wrByte   (wrByte),
    .stb      (stb),
    .byteEnd  (byteEnd),
    .txOut    (txOut)
  );

endmodule

// File: tb/sim_syncTxEofSeq.sv
`timescale 1ns/1ps
module sim_syncTxEofSeq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn;
  logic       enhMode = 1'b1;
  logic       syncMode = 1'b0;
  logic [7:0] syncByte = 8'hA5;
  logic       wrEn = 1'b0;
  logic [7:0] wrByte = 8'h00;
  logic       cmdArmEom = 1'b0;
  logic       cmdRstTxIp = 1'b0;
  logic       txOut, txBufEmpty, txIntPend, eomDone;

  int checks = 0;
  int failures = 0;
  int fillCnt = 0;
  int syncSeen = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [1:0] cyc;
  logic [2:0] bitPos;
  logic [7:0] monByte;
  logic [7:0] expQ[$];
  logic [15:0] crcModel;

  always #4 clk = ~clk; // 125 MHz

  syncTxEofSeq u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .enhMode(enhMode),
    .syncMode(syncMode), .syncByte(syncByte), .wrEn(wrEn), .wrByte(wrByte),
    .cmdArmEom(cmdArmEom), .cmdRstTxIp(cmdRstTxIp), .txOut(txOut),
    .txBufEmpty(txBufEmpty), .txIntPend(txIntPend), .eomDone(eomDone)
  );

  // Bench-side bit clock and bit position.
  assign bitEn = rstN && (cyc == 2'd3);
  always @(posedge clk) begin
    if (!rstN) begin
      cyc    <= 2'd0;
      bitPos <= 3'd0;
    end else begin
      cyc <= cyc + 2'd1;
      if (bitEn) bitPos <= bitPos + 3'd1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent CRC model: feed bits MSB first through a 16-bit LFSR.
  function automatic logic [15:0] crcFeed(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[15] ^ b[k];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // Monitor: rebuild line bytes and compare against the scoreboard.
  always @(negedge clk) begin
    if (rstN && bitEn && !finished) begin
      monByte[bitPos] = txOut;
      if (bitPos == 3'd7) begin
        if (expQ.size() != 0 && monByte == expQ[0]) begin
          void'(expQ.pop_front());
          check(1'b1, "R3 R5 R7 R9 stream", monByte, monByte);
        end else if (monByte == 8'h7E || (syncMode && monByte == syncByte)) begin
          fillCnt++;
          if (syncMode && monByte == syncByte) syncSeen++;
        end else begin
          check(1'b0, "R2 R5 R6 R7 R9 stream byte", monByte,
                expQ.size() != 0 ? expQ[0] : 8'h7E);
          if (expQ.size() != 0) void'(expQ.pop_front());
        end
      end
    end
  end

  task automatic writeByte(input logic [7:0] b);
    do @(negedge clk); while (!txBufEmpty);
    wrEn = 1'b1; wrByte = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseArm();
    @(negedge clk); cmdArmEom = 1'b1;
    @(negedge clk); cmdArmEom = 1'b0;
  endtask

  task automatic waitDrain();
    do @(negedge clk); while (expQ.size() != 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic pushData(input logic [7:0] b, input bit first);
    if (first) crcModel = 16'hFFFF;
    crcModel = crcFeed(crcModel, b);
    expQ.push_back(b);
  endtask

  task automatic pushCrc(input bit both);
    expQ.push_back(~crcModel[15:8]);
    if (both) expQ.push_back(~crcModel[7:0]);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txBufEmpty == 1'b1, "R1 txBufEmpty", txBufEmpty, 1);
    check(txIntPend == 1'b0, "R1 txIntPend", txIntPend, 0);
    check(eomDone == 1'b1, "R1 eomDone", eomDone, 1);
    repeat (100) @(negedge clk);
    check(fillCnt >= 2, "R1 R2 idle flag fill", fillCnt, 2);

    // Enhanced frame with CRC.
    pushData(8'h11, 1'b1);
    writeByte(8'h11);
    check(txBufEmpty == 1'b0, "R3 buffer full after write", txBufEmpty, 0);
    pulseArm();
    check(eomDone == 1'b0, "R4 latch armed", eomDone, 0);
    do @(negedge clk); while (!txBufEmpty);
    check(txIntPend == 1'b1, "R3 txIntPend on load", txIntPend, 1);
    pushData(8'h22, 1'b0); writeByte(8'h22);
    pushData(8'h33, 1'b0); writeByte(8'h33);
    pushCrc(1'b1);
    do @(negedge clk); while (!eomDone);
    check(eomDone == 1'b1, "R4 latch set at CRC load", eomDone, 1);

    // Enhanced window write: held behind CRC and flag.
    cmdRstTxIp = 1'b1; wrEn = 1'b1; wrByte = 8'h44;
    pushData(8'h44, 1'b1);
    @(negedge clk);
    cmdRstTxIp = 1'b0; wrEn = 1'b0;
    check(txIntPend == 1'b0, "R10 reset command clears", txIntPend, 0);
    do @(negedge clk); while (!txIntPend);
    check(txBufEmpty == 1'b0, "R8 buffer stays full at flag load", txBufEmpty, 0);
    pulseArm();
    pushData(8'h55, 1'b0); writeByte(8'h55);
    pushCrc(1'b1);
    waitDrain();
    check(eomDone == 1'b1, "R4 latch after second frame", eomDone, 1);

    // Sticky interrupt flag.
    repeat (50) @(negedge clk);
    check(txIntPend == 1'b1, "R10 txIntPend sticky", txIntPend, 1);
    @(negedge clk); cmdRstTxIp = 1'b1;
    @(negedge clk); cmdRstTxIp = 1'b0;
    check(txIntPend == 1'b0, "R10 txIntPend cleared", txIntPend, 0);

    // Underrun without arming: no CRC.
    pushData(8'h61, 1'b1); writeByte(8'h61);
    pushData(8'h62, 1'b0); writeByte(8'h62);
    waitDrain();
    repeat (100) @(negedge clk);
    check(eomDone == 1'b1, "R6 latch stays set", eomDone, 1);
    check(expQ.size() == 0, "R6 no check bytes", expQ.size(), 0);

    // Legacy: data pre-empts the low check byte.
    enhMode = 1'b0;
    pushData(8'h71, 1'b1); writeByte(8'h71);
    pulseArm();
    pushData(8'h72, 1'b0); writeByte(8'h72);
    pushCrc(1'b0);
    do @(negedge clk); while (!eomDone);
    wrEn = 1'b1; wrByte = 8'h81;
    pushData(8'h81, 1'b1);
    @(negedge clk);
    wrEn = 1'b0;
    pulseArm();
    pushData(8'h82, 1'b0); writeByte(8'h82);
    pushCrc(1'b1);
    waitDrain();
    check(expQ.size() == 0, "R9 aborted frame then new frame", expQ.size(), 0);

    // Set and reset of the interrupt flag in the same cycle.
    pushData(8'h91, 1'b1); writeByte(8'h91);
    do @(negedge clk); while (!(bitEn && bitPos == 3'd7));
    cmdRstTxIp = 1'b1;
    @(negedge clk);
    cmdRstTxIp = 1'b0;
    check(txIntPend == 1'b1, "R10 set wins over reset", txIntPend, 1);
    check(txBufEmpty == 1'b1, "R3 buffer drained at boundary", txBufEmpty, 1);
    waitDrain();

    // Sync fill.
    syncMode = 1'b1;
    repeat (200) @(negedge clk);
    check(syncSeen >= 3, "R2 sync byte fill", syncSeen, 3);
    check(expQ.size() == 0, "R2 scoreboard empty", expQ.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule